// File: doc/BRIEF.md
# Link Training Sequence Scheduler

This block decides, cycle by cycle, whether a packet transmitter may send data or must pause and put periodic training sequences on a SPI-4.2-style data path. The data path shows the block each 8-byte block it sends. With each block it also marks whether that block starts a packet and whether it closes the current burst. The block answers with a stall to the packet source, a training-active strobe and the number of the training repetition now on the wire. The block does not generate the training pattern.

Periodic training is set by two values. The first is the number of data cycles allowed between training episodes. The second is the number of pattern repetitions in each episode. Setting either value to zero turns periodic training off. An optional hold-off lets the opening burst of a packet reach a minimum length before a due episode begins. Later bursts of the same packet get no such protection. A loss-of-sync request makes training continuous until software drops the interface enable. Software raises the enable again to resume.

Top module: `train_sched`

## Requirements
- R1: While `if_en` is low, `stall` is 1 and `train_act` is 0 from the next cycle on. After reset and after every rise of `if_en`, a data phase (`stall`=0) begins one cycle later.
- R2: With periodic training on, each data phase lasts exactly `max_t` cycles. An episode then follows in which `stall`=1 and `train_act`=1 for `alpha`×`REP_CYC` cycles. During the episode `train_rep` counts 0 up to `alpha`-1, holding each value for `REP_CYC` cycles. The interval restarts from zero after every episode.
- R3: If `max_t`=0 or `alpha`=0, no periodic training ever starts and `stall` stays 0 while enabled.
- R4: `cfg_err` is 1 when periodic training is on and `max_t` is below 32 or not a multiple of 4. It is also 1 when `holdoff_en`=1 and `min_blocks` is odd. Otherwise it is 0.
- R5: When `holdoff_en`=1, a due episode waits while the burst opened by a block with `blk_sop`=1 is still open and has sent fewer than `min_blocks` blocks. The block that reaches the count ends the wait, and training starts on the next cycle.
- R6: A burst without a start-of-packet block is never protected. Neither is a first burst already closed by `blk_end`, nor any burst when `holdoff_en`=0. In all these cases training starts exactly on schedule.
- R7: With hold-off, a data phase never lasts longer than `max_t`+`min_blocks` cycles.
- R8: A one-cycle `sync_lost` pulse in a data phase starts training on the next cycle. Training then runs without a break, with `train_rep` counting through `alpha` repetitions and wrapping, until `if_en` falls.

Default parameters: `REP_CYC`=4, 16-bit interval and repeat count, 9-bit minimum-burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-path clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable |
| max_t | input | IVL_W | Data cycles between training episodes |
| alpha | input | ALPHA_W | Repetitions per episode |
| holdoff_en | input | 1 | Enable minimum first-burst hold-off |
| min_blocks | input | MINB_W | Minimum first-burst length in 8-byte blocks |
| blk_vld | input | 1 | One 8-byte block sent this cycle |
| blk_sop | input | 1 | This block starts a packet |
| blk_end | input | 1 | This block closes the burst |
| sync_lost | input | 1 | Loss-of-sync request (forces continuous training) |
| stall | output | 1 | Pause the packet source |
| train_act | output | 1 | Training pattern on the wire |
| train_rep | output | ALPHA_W | Current repetition in the episode |
| cfg_err | output | 1 | Illegal interval or minimum-burst setting |

## Verification
A wrong interval count shows up at the ports within one interval. The first `stall` rise then comes a cycle early or late against a fixed count of `max_t` data cycles. A wrong repetition counter changes the width of the `train_act` window, or the moment `train_rep` steps, within one episode. A first-burst tracker stuck open or stuck closed moves the start of training relative to the block count at the ports. A sticky sync flag that fails to clear shows up one cycle after `if_en` returns, as `train_act` where a data phase is expected.

// File: rtl/tsch_pkg.sv
package tsch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_TRAIN = 2'd2
  } tsch_state_e;
endpackage

// File: rtl/tsch_interval.sv
// Counts data-phase cycles; flags when the configured interval is used up.
module tsch_interval #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             per_en,
  input  logic [IVL_W-1:0] max_t,
  output logic             due
);
  logic [IVL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (cnt_q != '1)    cnt_d = cnt_q + IVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // last data cycle is the one holding count max_t-1 (saturated counts stay due)
  assign due = per_en && run &&
               (({1'b0, cnt_q} + (IVL_W+1)'(1)) >= {1'b0, max_t});
endmodule

// File: rtl/tsch_firstburst.sv
// Tracks the opening burst of a packet and requests hold-off until it is long enough.
module tsch_firstburst #(
  parameter int MINB_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              holdoff_en,
  input  logic [MINB_W-1:0] min_blocks,
  input  logic              blk_vld,
  input  logic              blk_sop,
  input  logic              blk_end,
  output logic              hold
);
  logic              open_q, open_d;
  logic [MINB_W-1:0] cnt_q, cnt_d;
  logic              sop_blk, open_now;
  logic [MINB_W-1:0] cnt_now;

  always_comb begin
    sop_blk  = blk_vld & blk_sop;
    open_now = (sop_blk | open_q) & ~(blk_vld & blk_end);
    if (sop_blk)            cnt_now = MINB_W'(1);
    else if (!open_q)       cnt_now = '0;
    else if (cnt_q == '1)   cnt_now = cnt_q;
    else                    cnt_now = cnt_q + MINB_W'(blk_vld);
    hold   = active & holdoff_en & open_now & (cnt_now < min_blocks);
    open_d = active & open_now;
    cnt_d  = active ? cnt_now : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/tsch_episode.sv
// Sequences the repetitions of one training episode.
module tsch_episode #(
  parameter int ALPHA_W = 16,
  parameter int REP_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [ALPHA_W-1:0] alpha,
  output logic [ALPHA_W-1:0] rep,
  output logic               done
);
  localparam int RC_W = (REP_CYC > 1) ? $clog2(REP_CYC) : 1;

  logic [RC_W-1:0]    cyc_q, cyc_d;
  logic [ALPHA_W-1:0] rep_q, rep_d;
  logic               last_cyc, last_rep;

  always_comb begin
    last_cyc = (cyc_q == RC_W'(REP_CYC - 1));
    last_rep = (({1'b0, rep_q} + (ALPHA_W+1)'(1)) >= {1'b0, alpha});
    done     = run & last_cyc & last_rep;
    cyc_d    = cyc_q;
    rep_d    = rep_q;
    if (!run || done) begin
      cyc_d = '0;
      rep_d = '0;
    end else if (last_cyc) begin
      cyc_d = '0;
      rep_d = rep_q + ALPHA_W'(1);
    end else begin
      cyc_d = cyc_q + RC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      rep_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      rep_q <= rep_d;
    end
  end

  assign rep = rep_q;
endmodule

// File: rtl/train_sched.sv
// Link training sequence scheduler: data/training phase control.
module train_sched
  import tsch_pkg::*;
#(
  parameter int IVL_W     = 16,
  parameter int ALPHA_W   = 16,
  parameter int MINB_W    = 9,
  parameter int REP_CYC   = 4,
  parameter int MIN_IVL   = 32,
  parameter int IVL_ALIGN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_en,
  input  logic [IVL_W-1:0]   max_t,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic               holdoff_en,
  input  logic [MINB_W-1:0]  min_blocks,
  input  logic               blk_vld,
  input  logic               blk_sop,
  input  logic               blk_end,
  input  logic               sync_lost,
  output logic               stall,
  output logic               train_act,
  output logic [ALPHA_W-1:0] train_rep,
  output logic               cfg_err
);
  tsch_state_e state_q, state_d;
  logic        lost_q, lost_d;
  logic        per_en, due_w, hold_w, done_w;

  assign per_en = (max_t != '0) && (alpha != '0);

  tsch_interval #(.IVL_W(IVL_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DATA),
    .per_en(per_en), .max_t(max_t), .due(due_w)
  );

  tsch_firstburst #(.MINB_W(MINB_W)) u_fb (
    .clk(clk), .rst_n(rst_n), .active(if_en), .holdoff_en(holdoff_en),
    .min_blocks(min_blocks), .blk_vld(blk_vld), .blk_sop(blk_sop),
    .blk_end(blk_end), .hold(hold_w)
  );

  tsch_episode #(.ALPHA_W(ALPHA_W), .REP_CYC(REP_CYC)) u_ep (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_TRAIN),
    .alpha(alpha), .rep(train_rep), .done(done_w)
  );

  always_comb begin
    lost_d  = if_en & (lost_q | sync_lost);
    state_d = state_q;
    if (!if_en) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:  state_d = ST_DATA;
        ST_DATA:  if (lost_d || (due_w && !hold_w)) state_d = ST_TRAIN;
        ST_TRAIN: if (done_w && !lost_d)            state_d = ST_DATA;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lost_q  <= lost_d;
    end
  end

  assign stall     = (state_q != ST_DATA);
  assign train_act = (state_q == ST_TRAIN);
  assign cfg_err   = (per_en && (((max_t % IVL_W'(IVL_ALIGN)) != '0) ||
                                 (max_t < IVL_W'(MIN_IVL)))) ||
                     (holdoff_en && min_blocks[0]);
endmodule

// File: rtl/train_sched_chk.sv
module train_sched_chk #(
  parameter int IVL_W   = 16,
  parameter int ALPHA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               if_en,
  input logic [IVL_W-1:0]   max_t,
  input logic [ALPHA_W-1:0] alpha,
  input logic               sync_lost,
  input logic               stall,
  input logic               train_act,
  input logic [ALPHA_W-1:0] train_rep,
  input logic               hold,
  input logic               lost
);
  a_r1_disabled_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (stall && !train_act));

  a_r2_train_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    train_act |-> stall);

  a_r2_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (train_act && alpha != '0) |-> (train_rep < alpha));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && !train_act && !sync_lost && (max_t == '0 || alpha == '0)) |=> !train_act);

  a_r5_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && !train_act && hold && !sync_lost && !lost) |=> !train_act);

  a_r8_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && if_en) |=> train_act);
endmodule

bind train_sched train_sched_chk #(.IVL_W(IVL_W), .ALPHA_W(ALPHA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .max_t(max_t), .alpha(alpha),
  .sync_lost(sync_lost), .stall(stall), .train_act(train_act),
  .train_rep(train_rep), .hold(hold_w), .lost(lost_q)
);

// File: tb/test_train_sched.sv
module test_train_sched;
  localparam int REP = 4;

  logic        clk, rst_n, if_en, holdoff_en, blk_vld, blk_sop, blk_end, sync_lost;
  logic [15:0] max_t, alpha, train_rep;
  logic [8:0]  min_blocks;
  logic        stall, train_act, cfg_err;

  int checks = 0, fails = 0;

  typedef struct {
    logic  st;
    logic  ac;
    int    rep;
    string req;
  } exp_t;
  exp_t q[$];

  train_sched i_train_sched (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .max_t(max_t), .alpha(alpha),
    .holdoff_en(holdoff_en), .min_blocks(min_blocks), .blk_vld(blk_vld),
    .blk_sop(blk_sop), .blk_end(blk_end), .sync_lost(sync_lost),
    .stall(stall), .train_act(train_act), .train_rep(train_rep), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compare one expected item per cycle, mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (stall !== e.st || train_act !== e.ac ||
          (e.ac && int'(train_rep) != e.rep)) begin
        fails++;
        $display("FAIL %s: stall/act/rep actual=%b/%b/%0d expected=%b/%b/%0d",
                 e.req, stall, train_act, train_rep, e.st, e.ac, e.rep);
      end
    end
  end

  task automatic step(input logic v, input logic s, input logic e,
                      input logic es, input logic ea, input int er, input string req);
    exp_t it;
    @(posedge clk); #2;
    blk_vld = v; blk_sop = s; blk_end = e;
    it.st = es; it.ac = ea; it.rep = er; it.req = req;
    q.push_back(it);
  endtask

  task automatic data_run(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1'b0, 1'b0, 0, req);
  endtask

  task automatic train_run(input int a, input string req);
    for (int i = 0; i < a * REP; i++) step(0, 0, 0, 1'b1, 1'b1, i / REP, req);
  endtask

  task automatic disable_if(input string req);
    if_en = 1'b0;
    step(0, 0, 0, 1'b1, 1'b0, 0, req);
    step(0, 0, 0, 1'b1, 1'b0, 0, req);
  endtask

  task automatic chk_cfg(input logic expv, input string req);
    #1;
    checks++;
    if (cfg_err !== expv) begin
      fails++;
      $display("FAIL %s: cfg_err actual=%b expected=%b", req, cfg_err, expv);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; if_en = 0; holdoff_en = 0; blk_vld = 0; blk_sop = 0; blk_end = 0;
    sync_lost = 0; max_t = 16'd32; alpha = 16'd2; min_blocks = 9'd6;
    repeat (3) @(negedge clk);
    checks++;
    if (stall !== 1'b1 || train_act !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: stall/act actual=%b/%b expected=1/0", stall, train_act);
    end
    @(posedge clk); #2; rst_n = 1;

    // R1/R2: periodic schedule
    disable_if("R1");
    if_en = 1'b1;
    data_run(32, "R2 data");
    train_run(2, "R2 train");
    data_run(32, "R2 restart");
    train_run(2, "R2 train2");
    disable_if("R1 disable");

    // R3: disabled periodic training
    max_t = 16'd0; alpha = 16'd2; if_en = 1'b1;
    data_run(100, "R3 max0");
    disable_if("R3");
    max_t = 16'd40; alpha = 16'd0; if_en = 1'b1;
    data_run(100, "R3 alpha0");
    disable_if("R3");

    // R4: configuration error flag
    alpha = 16'd2; holdoff_en = 1'b0;
    max_t = 16'd34; chk_cfg(1'b1, "R4 unaligned");
    max_t = 16'd28; chk_cfg(1'b1, "R4 small");
    max_t = 16'd32; chk_cfg(1'b0, "R4 legal");
    max_t = 16'd0;  chk_cfg(1'b0, "R4 off");
    max_t = 16'd32; holdoff_en = 1'b1; min_blocks = 9'd5; chk_cfg(1'b1, "R4 odd minb");
    min_blocks = 9'd6; chk_cfg(1'b0, "R4 even minb");

    // R5/R7: hold-off on first burst
    alpha = 16'd1; holdoff_en = 1'b1; min_blocks = 9'd6; if_en = 1'b1;
    data_run(28, "R5 pre");
    step(1, 1, 0, 1'b0, 1'b0, 0, "R5 sop");
    for (int k = 0; k < 5; k++) step(1, 0, 0, 1'b0, 1'b0, 0, "R5 R7 held");
    train_run(1, "R5 after hold");
    disable_if("R5");

    // R6: burst without start-of-packet is not protected
    if_en = 1'b1;
    data_run(28, "R6 pre");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 1'b0, 1'b0, 0, "R6 nosop");
    train_run(1, "R6 nosop train");
    disable_if("R6");

    // R6: first burst closed early
    if_en = 1'b1;
    data_run(30, "R6 pre2");
    step(1, 1, 0, 1'b0, 1'b0, 0, "R6 short sop");
    step(1, 0, 1, 1'b0, 1'b0, 0, "R6 short end");
    train_run(1, "R6 short train");
    disable_if("R6");

    // R6: hold-off disabled
    holdoff_en = 1'b0; if_en = 1'b1;
    data_run(28, "R6 pre3");
    step(1, 1, 0, 1'b0, 1'b0, 0, "R6 nohold sop");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1'b0, 1'b0, 0, "R6 nohold");
    train_run(1, "R6 nohold train");
    disable_if("R6");

    // R8: loss of sync -> continuous training until disable
    alpha = 16'd2; if_en = 1'b1;
    data_run(10, "R8 pre");
    sync_lost = 1'b1;
    step(0, 0, 0, 1'b1, 1'b1, 0, "R8 start");
    sync_lost = 1'b0;
    for (int i = 1; i < 40; i++) step(0, 0, 0, 1'b1, 1'b1, (i / REP) % 2, "R8 continuous");
    disable_if("R8 stop");
    if_en = 1'b1;
    data_run(32, "R8 R1 resume");
    train_run(2, "R8 resume train");

    @(negedge clk); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule